// File: doc/BRIEF.md
# Synchronizable four-port sample demultiplexer

This block accepts one sample per cycle of the sampling clock and spreads the samples over four parallel output ports, `port_a` to `port_d`, in a fixed rotation. The four ports are updated together once every four cycles, so downstream logic can run at a quarter of the sample rate. A divided data clock goes out with the ports. Its period depends on a two-bit mode input that selects single, double or quad data-rate output timing.

At power-up the internal divider starts in an unknown phase. This means the sample that lands on port A is not known in advance. Asserting the synchronous reset input clears the divider. After release, the first sample goes to port A. Several of these blocks released by the same reset therefore agree on sample order.

The block also delays the reset by seven and a half sampling-clock cycles and drives it out. This delayed reset can serve further demultiplexer stages further down the chain. The data clock keeps running while the delayed reset is still high, so those stages are clocked during their reset.

Top module: `dmx_sync_demux4`

## Requirements
- R1: A rising edge of `clk` with `rst_in` high clears the divider to phase 0. After that edge, `dclk_out` is 0 and all four ports are 0.
- R2: Number the samples taken after release k = 0, 1, 2, … . Sample k belongs to port A, B, C or D when k mod 4 is 0, 1, 2 or 3.
- R3: All ports change only on the rising edge that takes a port-D sample, which is the edge with k mod 4 = 3. That edge presents the group of four samples ending at that sample. Between such edges the ports hold their values.
- R4: On the first group update after release, only port D is loaded. Ports A to C keep the value 0 until the second group update.
- R5: With `mode` = 00 (single rate), `dclk_out` equals bit 1 of the count of rising edges since release. Its period is 4 cycles, and it starts low for two cycles.
- R6: With `mode` = 01 (double rate), `dclk_out` equals bit 2 of that count. Its period is 8 cycles.
- R7: With `mode` = 10 or 11 (quad rate), `dclk_out` equals bit 3 of that count. Its period is 16 cycles.
- R8: `rst_out` is `rst_in` delayed by 7.5 cycles in every mode. Each change of `rst_out` happens on the falling edge 7.5 periods after the first rising edge that samples the new level of `rst_in`.
- R9: After release, `dclk_out` keeps following R5–R7 during the cycles in which `rst_out` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_in | input | 1 | Synchronous active-high reset; aligns the divider phase |
| mode | input | 2 | Output rate: 00 single, 01 double, 10/11 quad |
| din | input | DW | One sample per clock |
| port_a | output | DW | Sample with k mod 4 = 0 of the last group |
| port_b | output | DW | Sample with k mod 4 = 1 of the last group |
| port_c | output | DW | Sample with k mod 4 = 2 of the last group |
| port_d | output | DW | Sample with k mod 4 = 3 of the last group |
| dclk_out | output | 1 | Divided output data clock |
| rst_out | output | 1 | Reset delayed by 7.5 clock cycles |

## Verification
Random bytes on `din` show whether any lane is crossed or shifted by one position. An incrementing ramp makes an off-by-one-group latency visible. Alternating all-ones and all-zeros words separate a port that is never loaded from one that is loaded with stale data. The bench runs every mode value, including the redundant quad code, and switches the mode during a run. A one-cycle reset pulse in the middle of a group shows that the rotation restarts at port A. The delay of `rst_out` is measured in time on both edges, and `dclk_out` is compared against a count of cycles since release.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int DMX_LANES = 4;
  localparam int DMX_PH_W  = $clog2(DMX_LANES);

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DOUBLE = 2'b01,
    MODE_QUAD   = 2'b10,
    MODE_QUAD_X = 2'b11
  } dmx_mode_e;

  // divider bit that drives the data clock for a given mode
  function automatic int unsigned dclk_tap(input logic [1:0] m);
    case (m)
      MODE_SINGLE: return 1;
      MODE_DOUBLE: return 2;
      default:     return 3;
    endcase
  endfunction
endpackage

// File: rtl/dmx_phase_gen.sv
module dmx_phase_gen
  import dmx_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic                clk,
  input  logic                rst_in,
  input  logic [1:0]          mode,
  output logic [DMX_PH_W-1:0] ph,
  output logic                dclk_out
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nxt;
  logic             dclk_q;

  assign div_nxt = div_q + DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst_in) begin
      div_q  <= '0;
      dclk_q <= 1'b0;
    end else begin
      div_q  <= div_nxt;
      dclk_q <= div_nxt[dclk_tap(mode)];
    end
  end

  assign ph       = div_q[DMX_PH_W-1:0];
  assign dclk_out = dclk_q;
endmodule

// File: rtl/dmx_lane_capture.sv
module dmx_lane_capture
  import dmx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_in,
  input  logic [DMX_PH_W-1:0] ph,
  input  logic [DW-1:0]       din,
  output logic [DW-1:0]       port_a,
  output logic [DW-1:0]       port_b,
  output logic [DW-1:0]       port_c,
  output logic [DW-1:0]       port_d
);
  localparam logic [DMX_PH_W-1:0] LAST_PH = DMX_PH_W'(DMX_LANES - 1);

  logic [DW-1:0] hold [DMX_LANES-1];
  logic          primed_q;

  // one staging register per lane except the last, which goes straight out
  for (genvar g = 0; g < DMX_LANES - 1; g++) begin : g_stage
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_in && ph == DMX_PH_W'(g)) q <= din;
    end
    assign hold[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst_in) begin
      port_a   <= '0;
      port_b   <= '0;
      port_c   <= '0;
      port_d   <= '0;
      primed_q <= 1'b0;
    end else if (ph == LAST_PH) begin
      port_d   <= din;
      primed_q <= 1'b1;
      if (primed_q) begin
        port_a <= hold[0];
        port_b <= hold[1];
        port_c <= hold[2];
      end
    end
  end
endmodule

// File: rtl/dmx_rst_delay.sv
module dmx_rst_delay #(
  // rising-edge stages; one falling-edge stage adds the half cycle
  parameter int RISE_STAGES = 8
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [RISE_STAGES-1:0] stg_q;
  logic                   half_q;

  always_ff @(posedge clk) begin
    stg_q <= {stg_q[RISE_STAGES-2:0], rst_in};
  end

  always_ff @(negedge clk) begin
    half_q <= stg_q[RISE_STAGES-1];
  end

  assign rst_out = half_q;
endmodule

// File: rtl/dmx_sync_demux4.sv
module dmx_sync_demux4
  import dmx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_in,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] port_a,
  output logic [DW-1:0] port_b,
  output logic [DW-1:0] port_c,
  output logic [DW-1:0] port_d,
  output logic          dclk_out,
  output logic          rst_out
);
  localparam int DIV_W = DMX_PH_W + 2;

  logic [DMX_PH_W-1:0] ph;

  dmx_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk      (clk),
    .rst_in   (rst_in),
    .mode     (mode),
    .ph       (ph),
    .dclk_out (dclk_out)
  );

  dmx_lane_capture #(.DW(DW)) u_lanes (
    .clk    (clk),
    .rst_in (rst_in),
    .ph     (ph),
    .din    (din),
    .port_a (port_a),
    .port_b (port_b),
    .port_c (port_c),
    .port_d (port_d)
  );

  dmx_rst_delay #(.RISE_STAGES(8)) u_rdly (
    .clk     (clk),
    .rst_in  (rst_in),
    .rst_out (rst_out)
  );
endmodule

// File: rtl/dmx_sync_demux4_chk.sv
module dmx_sync_demux4_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_in,
  input logic [1:0]    ph,
  input logic [DW-1:0] port_a,
  input logic [DW-1:0] port_d,
  input logic          dclk_out,
  input logic          rst_out
);
  logic [3:0] warm = 4'd0;
  always_ff @(posedge clk) if (warm != 4'd12) warm <= warm + 4'd1;

  AST_PHASE_CLEAR: assert property (@(posedge clk) rst_in |=> (ph == 2'd0)); // R1
  AST_PORTS_CLEAR: assert property (@(posedge clk) rst_in |=> (port_a == '0 && port_d == '0)); // R1
  AST_DCLK_LOW_IN_RESET: assert property (@(posedge clk) rst_in |=> !dclk_out); // R1
  AST_PORTS_HOLD_MID_GROUP: assert property (@(posedge clk) disable iff (rst_in)
    (ph != 2'd0) |-> ($stable(port_d) && $stable(port_a))); // R3
  AST_RST_OUT_DELAY: assert property (@(posedge clk) disable iff (warm != 4'd12)
    rst_out == $past(rst_in, 8)); // R8
endmodule

bind dmx_sync_demux4 dmx_sync_demux4_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_in   (rst_in),
  .ph       (ph),
  .port_a   (port_a),
  .port_d   (port_d),
  .dclk_out (dclk_out),
  .rst_out  (rst_out)
);

// File: tb/dmx_sync_demux4_bench.sv
`timescale 1ns/1ps
module dmx_sync_demux4_bench;
  localparam int DW = 8;
  localparam realtime PERIOD = 20.0;

  logic          clk = 1'b0;
  logic          rst_in = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] port_a, port_b, port_c, port_d;
  logic          dclk_out, rst_out;

  always #10 clk = ~clk;

  dmx_sync_demux4 #(.DW(DW)) u_dmx_sync_demux4 (
    .clk(clk), .rst_in(rst_in), .mode(mode), .din(din),
    .port_a(port_a), .port_b(port_b), .port_c(port_c), .port_d(port_d),
    .dclk_out(dclk_out), .rst_out(rst_out)
  );

  int checks = 0, fails = 0;
  int tchecks = 0, tfails = 0;
  bit done = 1'b0;

  // reference history built from the inputs only
  logic [DW-1:0] smp [0:255];
  int            kcnt = 0;
  int            edges = 0;
  logic [15:0]   rhist = '1;

  always @(posedge clk) begin
    rhist <= {rhist[14:0], rst_in};
    edges <= edges + 1;
    if (rst_in) kcnt <= 0;
    else begin
      smp[kcnt % 256] <= din;
      kcnt <= kcnt + 1;
    end
  end

  function automatic logic exp_dclk(int k, logic [1:0] m);
    int b;
    b = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 3;
    return logic'(((k % 16) >> b) & 1);
  endfunction

  function automatic logic [DW-1:0] exp_lane(int k, int lane);
    int w;
    w = k / 4;
    if (w == 0) return '0;
    if (lane != 3 && w == 1) return '0;
    return smp[(4 * (w - 1) + lane) % 256];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_check();
    int k;
    string dtag;
    @(negedge clk);
    #2;
    k = kcnt;
    if (k == 0) begin
      chk("R1 port_a", 32'(port_a), 0);
      chk("R1 port_d", 32'(port_d), 0);
      chk("R1 dclk", 32'(dclk_out), 0);
    end else begin
      chk("R2 port_a", 32'(port_a), 32'(exp_lane(k, 0)));
      chk(k / 4 == 1 ? "R4 port_b" : "R2 port_b", 32'(port_b), 32'(exp_lane(k, 1)));
      chk(k / 4 == 1 ? "R4 port_c" : "R2 port_c", 32'(port_c), 32'(exp_lane(k, 2)));
      chk("R3 port_d", 32'(port_d), 32'(exp_lane(k, 3)));
      dtag = (mode == 2'b00) ? "R5 dclk" : (mode == 2'b01) ? "R6 dclk" : "R7 dclk";
      if (rhist[7]) dtag = "R9 dclk during rst_out";
      chk(dtag, 32'(dclk_out), 32'(exp_dclk(k, mode)));
    end
    if (edges >= 8) chk("R8 rst_out level", 32'(rst_out), 32'(rhist[7]));
  endtask

  task automatic cyc(logic r, logic [1:0] m, logic [DW-1:0] d);
    step_check();
    rst_in = r;
    mode   = m;
    din    = d;
  endtask

  // delay of rst_out measured in time on both edges (R8)
  realtime t_rel = 0.0, t_asr = 0.0;
  logic    prev_r = 1'b1;
  always @(posedge clk) begin
    if (prev_r && !rst_in) t_rel = $realtime;
    if (!prev_r && rst_in) t_asr = $realtime;
    prev_r = rst_in;
  end
  always @(negedge rst_out) if (t_rel > 0.0) begin
    tchecks++;
    if (($realtime - t_rel) != 7.5 * PERIOD) begin
      tfails++;
      $display("FAIL R8 fall delay actual=%0t expected=%0t", $realtime - t_rel, 7.5 * PERIOD);
    end
  end
  always @(posedge rst_out) if (t_asr > 0.0) begin
    tchecks++;
    if (($realtime - t_asr) != 7.5 * PERIOD) begin
      tfails++;
      $display("FAIL R8 rise delay actual=%0t expected=%0t", $realtime - t_asr, 7.5 * PERIOD);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks + tchecks, fails + tfails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_0a17);
    // reset state: R1, and R8 after the delay line fills
    for (int i = 0; i < 10; i++) cyc(1'b1, 2'b00, '0);
    for (int mi = 0; mi < 4; mi++) begin
      for (int i = 0; i < 9; i++) cyc(1'b1, 2'(mi), 8'($urandom));
      cyc(1'b0, 2'(mi), 8'($urandom));
      for (int i = 0; i < 60; i++) begin
        logic [DW-1:0] d;
        case (mi)
          1:       d = 8'(i + 1);
          2:       d = (i % 2 == 0) ? 8'hFF : 8'h00;
          default: d = 8'($urandom);
        endcase
        cyc(1'b0, 2'(mi), d);
      end
    end
    // mode switch without reset: R5 and R7 on the same divider
    for (int i = 0; i < 20; i++) cyc(1'b0, 2'b00, 8'($urandom));
    for (int i = 0; i < 20; i++) cyc(1'b0, 2'b10, 8'($urandom));
    // one-cycle resync pulse in the middle of a group: R1 and R2
    cyc(1'b0, 2'b01, 8'($urandom));
    cyc(1'b1, 2'b01, 8'($urandom));
    for (int i = 0; i < 40; i++) cyc(1'b0, 2'b01, 8'($urandom));
    // long reset and a directed first group: R4
    for (int i = 0; i < 10; i++) cyc(1'b1, 2'b11, 8'hA5);
    cyc(1'b0, 2'b11, 8'h11);
    cyc(1'b0, 2'b11, 8'h22);
    cyc(1'b0, 2'b11, 8'h33);
    cyc(1'b0, 2'b11, 8'h44);
    for (int i = 0; i < 30; i++) cyc(1'b0, 2'b11, 8'($urandom));
    for (int i = 0; i < 12; i++) cyc(1'b1, 2'b00, '0);
    step_check();
    finish_run();
  end
endmodule